// File: doc/BRIEF.md
# Eight-bit accumulator ALU with status flags

This block is the arithmetic and register core of a small eight-bit processor. It owns the accumulator (A), the two index registers (X and Y) and the eight-bit processor status word. Each clock it takes a control kind, an opcode token and one operand byte M from the decoder and memory side. An executed operation updates the registers and drives a result byte. The next cycle shows the new status, X, Y and result on registered outputs, which go back to the sequencer and the store path.

The supported operations are loads, bitwise logic, add with carry in binary and decimal form, compares, increments and decrements of registers and of memory operands, shifts and rotate-left, flag clears, break, and the stack push and pull of A and status. Memory-target operations (increment, decrement, shifts and rotate of M) return their value on the result port and leave A untouched. Index-register operations change X or Y and leave the result port alone. Branches, jumps and no-op tokens go through without changing any state. A token outside the table is ignored and raises a sticky illegal-opcode output.

Top module: `acc_alu`

## Requirements
- R1: After `rst_n` low, or after a cycle with kind 2 (clear), A, X, Y and result read 0, status reads 8'h22 and `illegal` reads 0. A clear cycle takes effect on the next edge, just as an operation does.
- R2: With kind 0 (hold) or kind 3, no register or output changes, whatever the opcode and operand are. Only kind 1 (execute) runs the opcode.
- R3: An operation presented with kind 1 before a rising edge is visible on result, status, X, Y and illegal right after that edge, so the latency is one cycle. Status bit positions: C=0, Z=1, I=2, D=3, B=4, bit5 reads 1, V=6, N=7.
- R4: Loads: token 1 writes M to A and result; tokens 2 and 3 write M to X and Y only. All three set Z when M is 0 and copy M bit 7 into N.
- R5: Logic: tokens 4 (AND), 5 (OR) and 6 (XOR) combine A with M. They write the value to A and result and set Z and N from it.
- R6: Add (token 7) with D clear computes A+M+C into A and result. C is set when the full sum exceeds 255. V is set when A and M share a sign bit that differs from the sign of the result. Z and N follow the result.
- R7: Add with D set treats A and M as two packed decimal digits each. It writes the decimal sum modulo 100 to A and result, sets C when the decimal sum exceeds 99, sets Z and N from the result and leaves V unchanged.
- R8: Compares (token 8 against A, 9 against X, 10 against Y) set C when the register is at least M (unsigned) and set Z and N from the eight-bit difference. Result, A, X and Y are unchanged.
- R9: Bit test (token 11) sets Z when A AND M is zero and copies M bit 7 into N and M bit 6 into V. No register other than status changes.
- R10: Tokens 12/13 increment X/Y and tokens 14/15 decrement X/Y, with Z and N from the new value. Tokens 16/17 put M+1 / M-1 on result and set Z and N, leaving A, X and Y untouched.
- R11: Shift left (18 on A, 19 on M) and shift right (20 on A, 21 on M) move the bit shifted out into C. Rotate left (22 on A, 23 on M) also inserts the old C into bit 0. A-forms write A and result; M-forms write result only; Z and N follow the value.
- R12: Tokens 24..27 clear C, D, I and V, and token 28 sets B. Token 29 puts A on result and token 30 changes nothing. Token 31 loads A and result from M with Z and N. Token 32 loads status from M with bit 5 forced to 1.
- R13: Tokens 0 (no-op) and 33 (branch or jump pass-through) change no state. Tokens 34 and above change no register and set `illegal`, which stays set until a reset or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| kind | input | 2 | 0 hold, 1 execute, 2 clear, 3 hold |
| opcode | input | 6 | Operation token |
| operand | input | 8 | Operand byte M |
| result | output | 8 | Result byte |
| status | output | 8 | Processor status word |
| x_reg | output | 8 | X index register |
| y_reg | output | 8 | Y index register |
| illegal | output | 1 | Sticky unknown-opcode flag |

## Verification
The hardest state to reach from the ports is decimal addition: there is no set-decimal token, so the bench first pulls a status byte with D set (token 32) and then loads and adds packed decimal operands, including a sum that wraps past 99. The accumulator is never an output either, so its value after each shift, rotate and logic operation is brought out by following it with a push-A token and by the Z and N flags. Operations that must leave A alone (memory shifts, increments, compares) are followed by a push of A to prove it.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW  = 8;
  localparam int OPW = 6;
  localparam int KW  = 2;

  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FI = 2;
  localparam int FD = 3;
  localparam int FB = 4;
  localparam int FU = 5;
  localparam int FV = 6;
  localparam int FN = 7;

  localparam logic [DW-1:0] STATUS_INIT = DW'(8'h22);

  localparam logic [KW-1:0] K_HOLD  = 2'd0;
  localparam logic [KW-1:0] K_EXEC  = 2'd1;
  localparam logic [KW-1:0] K_CLEAR = 2'd2;

  typedef enum logic [OPW-1:0] {
    T_NOP  = 6'd0,  T_LDA  = 6'd1,  T_LDX  = 6'd2,  T_LDY  = 6'd3,
    T_AND  = 6'd4,  T_ORA  = 6'd5,  T_EOR  = 6'd6,  T_ADC  = 6'd7,
    T_CMP  = 6'd8,  T_CPX  = 6'd9,  T_CPY  = 6'd10, T_BIT  = 6'd11,
    T_INX  = 6'd12, T_INY  = 6'd13, T_DEX  = 6'd14, T_DEY  = 6'd15,
    T_INCM = 6'd16, T_DECM = 6'd17, T_ASLA = 6'd18, T_ASLM = 6'd19,
    T_LSRA = 6'd20, T_LSRM = 6'd21, T_ROLA = 6'd22, T_ROLM = 6'd23,
    T_CLC  = 6'd24, T_CLD  = 6'd25, T_CLI  = 6'd26, T_CLV  = 6'd27,
    T_BRK  = 6'd28, T_PHA  = 6'd29, T_PHP  = 6'd30, T_PLA  = 6'd31,
    T_PLP  = 6'd32, T_PASS = 6'd33
  } tok_e;

  typedef struct packed {
    logic [DW-1:0] a;
    logic [DW-1:0] x;
    logic [DW-1:0] y;
    logic [DW-1:0] p;
    logic [DW-1:0] r;
  } arch_t;

  function automatic logic [DW:0] add_bin(input logic [DW-1:0] a,
                                          input logic [DW-1:0] m,
                                          input logic c);
    return {1'b0, a} + {1'b0, m} + {{DW{1'b0}}, c};
  endfunction

  function automatic logic add_ovf(input logic [DW-1:0] a,
                                   input logic [DW-1:0] m,
                                   input logic [DW-1:0] s);
    return (a[DW-1] == m[DW-1]) && (s[DW-1] != a[DW-1]);
  endfunction

  function automatic logic [DW-1:0] put_zn(input logic [DW-1:0] p,
                                           input logic [DW-1:0] v);
    logic [DW-1:0] q;
    q     = p;
    q[FZ] = (v == '0);
    q[FN] = v[DW-1];
    return q;
  endfunction
endpackage

// File: rtl/alu_bcd_add.sv
module alu_bcd_add
  import alu_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout
);
  logic [5:0] lo_raw, hi_raw;
  logic [1:0] lo_car;
  logic [5:0] lo_dig, hi_dig;

  always_comb begin
    lo_raw = {2'b0, a[3:0]} + {2'b0, m[3:0]} + {5'b0, cin};
    if (lo_raw >= 6'd30)      lo_car = 2'd3;
    else if (lo_raw >= 6'd20) lo_car = 2'd2;
    else if (lo_raw >= 6'd10) lo_car = 2'd1;
    else                      lo_car = 2'd0;
    lo_dig = lo_raw - 6'd10 * {4'b0, lo_car};
    hi_raw = {2'b0, a[7:4]} + {2'b0, m[7:4]} + {4'b0, lo_car};
    cout   = (hi_raw >= 6'd10);
    if (hi_raw >= 6'd30)      hi_dig = hi_raw - 6'd30;
    else if (hi_raw >= 6'd20) hi_dig = hi_raw - 6'd20;
    else if (hi_raw >= 6'd10) hi_dig = hi_raw - 6'd10;
    else                      hi_dig = hi_raw;
    sum = {hi_dig[3:0], lo_dig[3:0]};
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
(
  input  arch_t          cur,
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  m,
  output arch_t          nxt,
  output logic           bad_op,
  output logic           bin_carry,
  output logic           bin_ovf
);
  logic [DW:0]   bin_sum;
  logic [DW-1:0] dec_sum;
  logic          dec_carry;
  logic [DW-1:0] cmp_reg;
  logic [DW-1:0] cmp_diff;
  logic [DW-1:0] v;

  assign bin_sum   = add_bin(cur.a, m, cur.p[FC]);
  assign bin_carry = bin_sum[DW];
  assign bin_ovf   = add_ovf(cur.a, m, bin_sum[DW-1:0]);

  alu_bcd_add u_bcd (
    .a   (cur.a),
    .m   (m),
    .cin (cur.p[FC]),
    .sum (dec_sum),
    .cout(dec_carry)
  );

  always_comb begin
    case (op)
      T_CPX:   cmp_reg = cur.x;
      T_CPY:   cmp_reg = cur.y;
      default: cmp_reg = cur.a;
    endcase
    cmp_diff = cmp_reg - m;
  end

  always_comb begin
    nxt    = cur;
    bad_op = 1'b0;
    v      = '0;
    case (op)
      T_NOP, T_PASS, T_PHP: ;
      T_LDA:  begin nxt.a = m; nxt.r = m; nxt.p = put_zn(cur.p, m); end
      T_LDX:  begin nxt.x = m; nxt.p = put_zn(cur.p, m); end
      T_LDY:  begin nxt.y = m; nxt.p = put_zn(cur.p, m); end
      T_AND, T_ORA, T_EOR: begin
        if (op == T_AND)      v = cur.a & m;
        else if (op == T_ORA) v = cur.a | m;
        else                  v = cur.a ^ m;
        nxt.a = v; nxt.r = v; nxt.p = put_zn(cur.p, v);
      end
      T_ADC: begin
        if (cur.p[FD]) begin
          v = dec_sum;
          nxt.p = put_zn(cur.p, v);
          nxt.p[FC] = dec_carry;
        end else begin
          v = bin_sum[DW-1:0];
          nxt.p = put_zn(cur.p, v);
          nxt.p[FC] = bin_carry;
          nxt.p[FV] = bin_ovf;
        end
        nxt.a = v; nxt.r = v;
      end
      T_CMP, T_CPX, T_CPY: begin
        nxt.p = put_zn(cur.p, cmp_diff);
        nxt.p[FC] = (cmp_reg >= m);
      end
      T_BIT: begin
        nxt.p[FZ] = ((cur.a & m) == '0);
        nxt.p[FN] = m[7];
        nxt.p[FV] = m[6];
      end
      T_INX:  begin nxt.x = cur.x + 1'b1; nxt.p = put_zn(cur.p, nxt.x); end
      T_INY:  begin nxt.y = cur.y + 1'b1; nxt.p = put_zn(cur.p, nxt.y); end
      T_DEX:  begin nxt.x = cur.x - 1'b1; nxt.p = put_zn(cur.p, nxt.x); end
      T_DEY:  begin nxt.y = cur.y - 1'b1; nxt.p = put_zn(cur.p, nxt.y); end
      T_INCM: begin nxt.r = m + 1'b1; nxt.p = put_zn(cur.p, nxt.r); end
      T_DECM: begin nxt.r = m - 1'b1; nxt.p = put_zn(cur.p, nxt.r); end
      T_ASLA, T_ROLA: begin
        v = {cur.a[DW-2:0], (op == T_ROLA) ? cur.p[FC] : 1'b0};
        nxt.a = v; nxt.r = v;
        nxt.p = put_zn(cur.p, v); nxt.p[FC] = cur.a[DW-1];
      end
      T_ASLM, T_ROLM: begin
        v = {m[DW-2:0], (op == T_ROLM) ? cur.p[FC] : 1'b0};
        nxt.r = v;
        nxt.p = put_zn(cur.p, v); nxt.p[FC] = m[DW-1];
      end
      T_LSRA: begin
        v = {1'b0, cur.a[DW-1:1]};
        nxt.a = v; nxt.r = v;
        nxt.p = put_zn(cur.p, v); nxt.p[FC] = cur.a[0];
      end
      T_LSRM: begin
        v = {1'b0, m[DW-1:1]};
        nxt.r = v;
        nxt.p = put_zn(cur.p, v); nxt.p[FC] = m[0];
      end
      T_CLC:  nxt.p[FC] = 1'b0;
      T_CLD:  nxt.p[FD] = 1'b0;
      T_CLI:  nxt.p[FI] = 1'b0;
      T_CLV:  nxt.p[FV] = 1'b0;
      T_BRK:  nxt.p[FB] = 1'b1;
      T_PHA:  nxt.r = cur.a;
      T_PLA:  begin nxt.a = m; nxt.r = m; nxt.p = put_zn(cur.p, m); end
      T_PLP:  begin nxt.p = m; nxt.p[FU] = 1'b1; end
      default: bad_op = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_state.sv
module alu_state
  import alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] kind,
  input  arch_t         nxt,
  input  logic          bad_op,
  output arch_t         cur,
  output logic          illegal
);
  logic run_op, clear_op;
  assign run_op   = (kind == K_EXEC);
  assign clear_op = (kind == K_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= '{a: '0, x: '0, y: '0, p: STATUS_INIT, r: '0};
      illegal <= 1'b0;
    end else if (clear_op) begin
      cur     <= '{a: '0, x: '0, y: '0, p: STATUS_INIT, r: '0};
      illegal <= 1'b0;
    end else if (run_op) begin
      cur     <= nxt;
      illegal <= illegal | bad_op;
    end
  end

  // R2: hold and spare kinds freeze every register
  a_r2_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_op && !clear_op) |=> ($stable(cur) && $stable(illegal)));

  // R1: a clear cycle restores the reset image
  a_r1_clear_image: assert property (@(posedge clk) disable iff (!rst_n)
    clear_op |=> (cur.a == '0 && cur.x == '0 && cur.y == '0 &&
                  cur.r == '0 && cur.p == STATUS_INIT && !illegal));

  // R12: status bit 5 always reads one
  a_r12_bit5_set: assert property (@(posedge clk) disable iff (!rst_n)
    cur.p[FU]);

  // R13: the illegal flag is sticky until a clear
  a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !clear_op) |=> illegal);

  // R13: an unknown token leaves the registers alone and sets the flag
  a_r13_unknown_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (run_op && bad_op) |=> (illegal && $stable(cur)));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] kind,
  input  logic [OPW-1:0] opcode,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result,
  output logic [DW-1:0] status,
  output logic [DW-1:0] x_reg,
  output logic [DW-1:0] y_reg,
  output logic          illegal
);
  arch_t cur, nxt;
  logic  bad_op, bin_carry, bin_ovf;

  alu_exec u_exec (
    .cur      (cur),
    .op       (opcode),
    .m        (operand),
    .nxt      (nxt),
    .bad_op   (bad_op),
    .bin_carry(bin_carry),
    .bin_ovf  (bin_ovf)
  );

  alu_state u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (kind),
    .nxt    (nxt),
    .bad_op (bad_op),
    .cur    (cur),
    .illegal(illegal)
  );

  assign result = cur.r;
  assign status = cur.p;
  assign x_reg  = cur.x;
  assign y_reg  = cur.y;

  // R6: a binary add that overflows unsigned sets C in the next cycle
  a_r6_carry_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_EXEC && opcode == T_ADC && !cur.p[FD] && bin_carry) |=> status[FC]);

  // R8: compares never touch result, X or Y
  a_r8_cmp_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_EXEC && (opcode == T_CMP || opcode == T_CPX || opcode == T_CPY))
      |=> ($stable(result) && $stable(x_reg) && $stable(y_reg)));
endmodule

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [5:0] opcode = 6'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] result, status, x_reg, y_reg;
  logic       illegal;

  always #2 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .kind(kind), .opcode(opcode), .operand(operand),
    .result(result), .status(status), .x_reg(x_reg), .y_reg(y_reg), .illegal(illegal)
  );

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct packed {
    logic [7:0] r, p, x, y;
    logic       il;
  } snap_t;

  snap_t q_exp[$];
  string q_tag[$];
  int    q_due[$];

  logic [7:0] ma = 0, mx = 0, my = 0, mp = 8'h22, mr = 0;
  logic       mi = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input snap_t e, input string tag);
    n_run++;
    if (result !== e.r || status !== e.p || x_reg !== e.x || y_reg !== e.y || illegal !== e.il) begin
      n_fail++;
      $display("FAIL %s: got r=%h p=%h x=%h y=%h il=%b expected r=%h p=%h x=%h y=%h il=%b",
               tag, result, status, x_reg, y_reg, illegal, e.r, e.p, e.x, e.y, e.il);
    end
  endtask

  always @(negedge clk) begin
    if (q_exp.size() > 0 && q_due[0] <= cyc) begin
      compare(q_exp[0], q_tag[0]);
      void'(q_exp.pop_front());
      void'(q_tag.pop_front());
      void'(q_due.pop_front());
    end
  end

  function automatic void zn(input logic [7:0] v);
    mp[1] = (v == 8'h00);
    mp[7] = v[7];
  endfunction

  function automatic int bcd_val(input logic [7:0] b);
    return 10 * int'(b[7:4]) + int'(b[3:0]);
  endfunction

  task automatic model(input logic [1:0] k, input logic [5:0] op, input logic [7:0] m);
    logic [8:0] s;
    int d;
    if (k == 2'd2) begin
      ma = 0; mx = 0; my = 0; mr = 0; mp = 8'h22; mi = 0;
    end else if (k == 2'd1) begin
      case (op)
        1:  begin ma = m; mr = m; zn(m); end
        2:  begin mx = m; zn(m); end
        3:  begin my = m; zn(m); end
        4:  begin ma = ma & m; mr = ma; zn(ma); end
        5:  begin ma = ma | m; mr = ma; zn(ma); end
        6:  begin ma = ma ^ m; mr = ma; zn(ma); end
        7:  if (mp[3]) begin
              d = bcd_val(ma) + bcd_val(m) + int'(mp[0]);
              mp[0] = (d > 99);
              d = d % 100;
              ma = 8'((d / 10) * 16 + (d % 10)); mr = ma; zn(ma);
            end else begin
              s = 9'(ma) + 9'(m) + 9'(mp[0]);
              mp[0] = s[8];
              mp[6] = (ma[7] == m[7]) && (s[7] != ma[7]);
              ma = s[7:0]; mr = ma; zn(ma);
            end
        8, 9, 10: begin
              s[7:0] = (op == 8) ? ma : (op == 9) ? mx : my;
              mp[0] = (s[7:0] >= m);
              zn(s[7:0] - m);
            end
        11: begin mp[1] = ((ma & m) == 0); mp[7] = m[7]; mp[6] = m[6]; end
        12: begin mx = mx + 1; zn(mx); end
        13: begin my = my + 1; zn(my); end
        14: begin mx = mx - 1; zn(mx); end
        15: begin my = my - 1; zn(my); end
        16: begin mr = m + 1; zn(mr); end
        17: begin mr = m - 1; zn(mr); end
        18: begin mp[0] = ma[7]; ma = ma * 2; mr = ma; zn(ma); end
        19: begin mp[0] = m[7]; mr = m * 2; zn(mr); end
        20: begin mp[0] = ma[0]; ma = ma / 2; mr = ma; zn(ma); end
        21: begin mp[0] = m[0]; mr = m / 2; zn(mr); end
        22: begin s[0] = mp[0]; mp[0] = ma[7]; ma = ma * 2 + 8'(s[0]); mr = ma; zn(ma); end
        23: begin s[0] = mp[0]; mp[0] = m[7]; mr = m * 2 + 8'(s[0]); zn(mr); end
        24: mp[0] = 0;
        25: mp[3] = 0;
        26: mp[2] = 0;
        27: mp[6] = 0;
        28: mp[4] = 1;
        29: mr = ma;
        31: begin ma = m; mr = m; zn(m); end
        32: mp = m | 8'h20;
        0, 30, 33: ;
        default: mi = 1;
      endcase
    end
  endtask

  task automatic step(input logic [1:0] k, input logic [5:0] op, input logic [7:0] m,
                      input string tag);
    @(negedge clk);
    kind = k; opcode = op; operand = m;
    model(k, op, m);
    q_exp.push_back('{r: mr, p: mp, x: mx, y: my, il: mi});
    q_tag.push_back(tag);
    q_due.push_back(cyc + 1);
  endtask

  task automatic ex(input logic [5:0] op, input logic [7:0] m, input string tag);
    step(2'd1, op, m, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare('{r: 8'h00, p: 8'h22, x: 8'h00, y: 8'h00, il: 1'b0}, "R1 in async reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare('{r: 8'h00, p: 8'h22, x: 8'h00, y: 8'h00, il: 1'b0}, "R1 after reset release");

    ex(1, 8'h00, "R4 R3 lda zero");
    ex(1, 8'h80, "R4 lda negative");
    ex(2, 8'h05, "R4 ldx");
    ex(3, 8'hFF, "R4 ldy negative");
    ex(4, 8'h0F, "R5 and to zero");
    ex(1, 8'h3C, "R4 lda");
    ex(5, 8'hC3, "R5 or");
    ex(6, 8'hFF, "R5 xor to zero");
    ex(32, 8'h00, "R12 plp zero forces bit5");
    ex(1, 8'h50, "R4 lda");
    ex(7, 8'h50, "R6 adc signed overflow");
    ex(7, 8'h70, "R6 adc unsigned carry");
    ex(7, 8'h01, "R6 adc with carry in");
    ex(8, 8'h12, "R8 cmp equal");
    ex(8, 8'h13, "R8 cmp less");
    ex(9, 8'h05, "R8 cpx equal");
    ex(10, 8'h00, "R8 cpy greater");
    ex(11, 8'hC0, "R9 bit zero with n v");
    ex(11, 8'h12, "R9 bit nonzero");
    ex(12, 8'h00, "R10 inx");
    ex(13, 8'h00, "R10 iny wrap");
    ex(14, 8'h00, "R10 dex");
    ex(15, 8'h00, "R10 dey wrap");
    ex(16, 8'hFF, "R10 inc memory wrap");
    ex(17, 8'h00, "R10 dec memory wrap");
    ex(29, 8'h00, "R10 pha shows A untouched");
    ex(1, 8'h81, "R4 lda");
    ex(18, 8'h00, "R11 asl A");
    ex(20, 8'h00, "R11 lsr A");
    ex(22, 8'h00, "R11 rol A");
    ex(19, 8'h81, "R11 asl memory");
    ex(21, 8'h01, "R11 lsr memory");
    ex(23, 8'h40, "R11 rol memory");
    ex(29, 8'h00, "R11 pha shows A kept by memory forms");
    ex(32, 8'hFF, "R12 plp all ones");
    ex(24, 8'h00, "R12 clc");
    ex(25, 8'h00, "R12 cld");
    ex(26, 8'h00, "R12 cli");
    ex(27, 8'h00, "R12 clv");
    ex(32, 8'h00, "R12 plp");
    ex(28, 8'h00, "R12 brk");
    ex(30, 8'h77, "R12 php no change");
    ex(31, 8'h00, "R12 pla zero");
    ex(32, 8'h08, "R7 plp sets decimal");
    ex(1, 8'h58, "R7 lda");
    ex(7, 8'h46, "R7 decimal add wraps");
    ex(7, 8'h12, "R7 decimal add with carry");
    step(2'd0, 6'd1, 8'h99, "R2 hold ignores load");
    step(2'd3, 6'd12, 8'h00, "R2 kind 3 ignores inx");
    ex(0, 8'h55, "R13 nop");
    ex(33, 8'hAA, "R13 pass-through");
    ex(40, 8'h00, "R13 unknown token sets flag");
    ex(12, 8'h00, "R13 flag stays set");
    step(2'd2, 6'd1, 8'h44, "R1 clear kind");
    ex(29, 8'h00, "R1 A is zero after clear");
    step(2'd0, 6'd0, 8'h00, "R2 idle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule